// File: doc/BRIEF.md
# Iterative Integer Multiplier with Condition Flags

This block is the multiply execution unit of a processor datapath. It receives two 32-bit operand values, a signedness select and a form select. It returns a product split into a high word and a low word, together with a five-bit flag group. Instruction decode, operand fetch and register write-back sit outside the block. The decoder supplies the form and signedness it extracts from the instruction.

Three forms exist. The word form multiplies the low 16 bits of each operand into a 32-bit product. The long-truncated form multiplies two 32-bit operands and keeps the low 32 bits, reporting overflow when the discarded half carries information. The long-wide form keeps the full 64-bit product. The magnitudes are multiplied by an MSB-first shift-add loop that takes one iteration per operand bit. A final negation step restores the sign when the operands' signs differ.

A state machine sequences the work and has four named states:
- ST_IDLE waits for `start`. It moves to ST_RUN when `start` is seen, and that transition loads the operands.
- ST_RUN performs one shift-add per cycle. It moves to ST_FIX when the iteration counter reaches its last count.
- ST_FIX applies the sign, registers the result and flags, and moves to ST_DONE.
- ST_DONE raises `done` for one cycle and returns to ST_IDLE.

Top module: `mulx_unit`

## Requirements
- R1: With `form`=0 (word), only `opa[15:0]` and `opb[15:0]` are used and the upper operand bits have no effect. `res_lo` is their 32-bit product. `res_hi` is the upper half of that product extended to 64 bits: all ones for a negative signed product, zero otherwise.
- R2: With `form`=1 (long truncated), `res_lo` is the low 32 bits of the product of the two 32-bit operands, and `res_hi` is its upper 32 bits.
- R3: With `form`=2 (long wide), `{res_hi,res_lo}` is the full 64-bit product. A `form` value of 3 behaves exactly as 2.
- R4: `is_signed`=1 treats the operands as two's complement numbers, and `is_signed`=0 treats them as unsigned.
- R5: `flags[3]` (N) equals bit 31 of the result in forms 0 and 1, and bit 63 of the 64-bit result in the wide form.
- R6: `flags[2]` (Z) is set when all 32 result bits are zero (forms 0 and 1), or all 64 bits are zero (wide form).
- R7: `flags[1]` (V) is set only in form 1. For signed operation it is set when `res_hi` is not 32 copies of `res_lo[31]`. For unsigned operation it is set when `res_hi` is non-zero.
- R8: `flags[0]` (C) is always 0. `flags[4]` (X) equals the `x_in` value sampled with the accepted `start`.
- R9: An accepted start raises `busy` on the next cycle. `done` is high for exactly one cycle, 18 cycles after the start edge for the word form and 34 cycles after it for the long forms. `busy` stays high until that cycle.
- R10: `start` is accepted only when `busy` and `done` are both low. A start pulse at other times does not change the result of the multiply in progress.
- R11: After reset, `busy`, `done`, `res_hi`, `res_lo` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiply (when idle) |
| is_signed | input | 1 | 1 = signed, 0 = unsigned |
| form | input | 2 | 0 word, 1 long truncated, 2 or 3 long wide |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| x_in | input | 1 | Current extend flag, passed through unchanged |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle result-valid pulse |
| res_hi | output | 32 | Upper product word |
| res_lo | output | 32 | Lower product word |
| flags | output | 5 | {X, N, Z, V, C} |

## Verification
The bench targets the following corner cases:
- The most-negative value times itself, in every form. A magnitude converter that mishandles this value returns a wrong sign or a zero product.
- Products with minus one. A design that negates in 32 bits instead of 64 leaves `res_hi` zero here.
- Products with zero under a negative sign. A design that does this wrong gives a non-zero result or a wrong Z flag.
- All-ones unsigned operands. A design that sign-extends in unsigned mode gets the product wrong.
- Truncated results that only just fit or only just overflow in either signedness. A wrong sign-extension test for V shows up here.
- A start pulse mid-run and garbage in the upper operand bits of the word form. A design that does not ignore these inputs corrupts the result.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
    localparam int DW = 32;
    localparam int HW = DW / 2;
    localparam int PW = 2 * DW;

    typedef enum logic [1:0] {
        FM_WORD     = 2'd0,
        FM_LONG     = 2'd1,
        FM_WIDE     = 2'd2,
        FM_WIDE_ALT = 2'd3
    } form_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIX,
        ST_DONE
    } mstate_t;
endpackage

// File: rtl/mulx_prep.sv
module mulx_prep
    import mulx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         is_signed,
    input  logic         word_mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mcand,
    output logic [W-1:0] mplr,
    output logic         neg
);
    localparam int H = W / 2;

    logic [W-1:0] ext_a, ext_b, mag_a, mag_b;
    logic         sa, sb;

    always_comb begin
        if (word_mode) begin
            ext_a = is_signed ? {{H{a[H-1]}}, a[H-1:0]} : {{H{1'b0}}, a[H-1:0]};
            ext_b = is_signed ? {{H{b[H-1]}}, b[H-1:0]} : {{H{1'b0}}, b[H-1:0]};
        end else begin
            ext_a = a;
            ext_b = b;
        end
        sa    = is_signed & ext_a[W-1];
        sb    = is_signed & ext_b[W-1];
        mag_a = sa ? (~ext_a + 1'b1) : ext_a;
        mag_b = sb ? (~ext_b + 1'b1) : ext_b;
        neg   = sa ^ sb;
        mcand = mag_a;
        // MSB-first loop: word multiplier is left-aligned so H steps suffice
        mplr  = word_mode ? {mag_b[H-1:0], {H{1'b0}}} : mag_b;
    end
endmodule

// File: rtl/mulx_core.sv
module mulx_core
    import mulx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplr_in,
    input  logic           neg_in,
    output logic [2*W-1:0] prod
);
    logic [2*W-1:0] acc;
    logic [W-1:0]   mcand_q, mplr_q;
    logic           neg_q;
    logic [2*W-1:0] addend;

    assign addend = mplr_q[W-1] ? {{W{1'b0}}, mcand_q} : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            mcand_q <= '0;
            mplr_q  <= '0;
            neg_q   <= 1'b0;
        end else if (load) begin
            acc     <= '0;
            mcand_q <= mcand_in;
            mplr_q  <= mplr_in;
            neg_q   <= neg_in;
        end else if (step) begin
            acc    <= {acc[2*W-2:0], 1'b0} + addend;
            mplr_q <= {mplr_q[W-2:0], 1'b0};
        end
    end

    assign prod = neg_q ? (~acc + 1'b1) : acc;
endmodule

// File: rtl/mulx_flags.sv
module mulx_flags
    import mulx_pkg::*;
#(
    parameter int W = DW
) (
    input  form_t          form,
    input  logic           is_signed,
    input  logic [2*W-1:0] prod,
    output logic           n,
    output logic           z,
    output logic           v
);
    logic [W-1:0] hi, lo;
    assign hi = prod[2*W-1:W];
    assign lo = prod[W-1:0];

    always_comb begin
        unique case (form)
            FM_WIDE, FM_WIDE_ALT: begin
                n = prod[2*W-1];
                z = (prod == '0);
                v = 1'b0;
            end
            FM_LONG: begin
                n = lo[W-1];
                z = (lo == '0);
                v = is_signed ? (hi != {W{lo[W-1]}}) : (hi != '0);
            end
            default: begin
                n = lo[W-1];
                z = (lo == '0);
                v = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
    import mulx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [1:0]   form,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         x_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo,
    output logic [4:0]   flags
);
    localparam int H  = W / 2;
    localparam int CW = $clog2(W + 1);

    mstate_t        state, state_nx;
    logic [CW-1:0]  cnt;
    form_t          form_q;
    logic           sgn_q, x_q;
    logic           load, step, fix;
    logic           in_word;
    logic [W-1:0]   p_mcand, p_mplr;
    logic           p_neg;
    logic [2*W-1:0] prod;
    logic           fn, fz, fv;

    assign in_word = (form == FM_WORD);

    mulx_prep #(.W(W)) prep_i (
        .is_signed (is_signed),
        .word_mode (in_word),
        .a         (opa),
        .b         (opb),
        .mcand     (p_mcand),
        .mplr      (p_mplr),
        .neg       (p_neg)
    );

    mulx_core #(.W(W)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .mcand_in (p_mcand),
        .mplr_in  (p_mplr),
        .neg_in   (p_neg),
        .prod     (prod)
    );

    mulx_flags #(.W(W)) flags_i (
        .form      (form_q),
        .is_signed (sgn_q),
        .prod      (prod),
        .n         (fn),
        .z         (fz),
        .v         (fv)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (cnt == CW'(1)) state_nx = ST_FIX;
            ST_FIX:  state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // control decode
    assign load = (state == ST_IDLE) && start;
    assign step = (state == ST_RUN);
    assign fix  = (state == ST_FIX);
    assign busy = (state == ST_RUN) || (state == ST_FIX);
    assign done = (state == ST_DONE);

    // output and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            form_q <= FM_WORD;
            sgn_q  <= 1'b0;
            x_q    <= 1'b0;
            res_hi <= '0;
            res_lo <= '0;
            flags  <= '0;
        end else begin
            if (load) begin
                cnt    <= in_word ? CW'(H) : CW'(W);
                form_q <= (form_t'(form) == FM_WIDE_ALT) ? FM_WIDE : form_t'(form);
                sgn_q  <= is_signed;
                x_q    <= x_in;
            end else if (step) begin
                cnt <= cnt - 1'b1;
            end
            if (fix) begin
                res_hi <= prod[2*W-1:W];
                res_lo <= prod[W-1:0];
                flags  <= {x_q, fn, fz, fv, 1'b0};
            end
        end
    end

    // R9: done lasts one cycle
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy is held until the done cycle
    a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R10: an idle start is taken
    a_r10_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    // R7: overflow only in the truncated long form
    a_r7_v_only_long: assert property (@(posedge clk) disable iff (!rst_n)
        (done && form_q != FM_LONG) |-> !flags[1]);

    // R6: zero result is never negative
    a_r6_zero_not_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[2]) |-> !flags[3]);
endmodule

// File: tb/mulx_unit_tb_top.sv
`timescale 1ns/1ps
module mulx_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [1:0]  form = 2'd0;
    logic [31:0] opa = '0, opb = '0;
    logic        x_in = 1'b0;
    logic        busy, done;
    logic [31:0] res_hi, res_lo;
    logic [4:0]  flags;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    mulx_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .form(form), .opa(opa), .opb(opb), .x_in(x_in),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo), .flags(flags)
    );

    // {form, is_signed, x_in, opa, opb}
    localparam int NV = 18;
    localparam logic [67:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b0, 32'h0000_8000, 32'h0000_8000},
        {2'd0, 1'b1, 1'b1, 32'h0000_FFFF, 32'h0000_0003},
        {2'd0, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF},
        {2'd0, 1'b1, 1'b1, 32'hDEAD_FFFB, 32'h0000_0000},
        {2'd0, 1'b0, 1'b0, 32'hABCD_1234, 32'h5A5A_0100},
        {2'd1, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000},
        {2'd1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0007},
        {2'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {2'd1, 1'b0, 1'b0, 32'h0001_0000, 32'h0001_0000},
        {2'd1, 1'b1, 1'b0, 32'h0001_0000, 32'h0000_8000},
        {2'd1, 1'b1, 1'b1, 32'hFFFF_0000, 32'h0000_8000},
        {2'd1, 1'b0, 1'b0, 32'h0001_0000, 32'h0000_8000},
        {2'd2, 1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000},
        {2'd2, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001},
        {2'd2, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {2'd2, 1'b1, 1'b1, 32'h8000_0000, 32'h0000_0000},
        {2'd3, 1'b1, 1'b0, 32'h1234_5678, 32'hFEDC_BA98},
        {2'd2, 1'b1, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference result from the requirements
    task automatic model(input logic [1:0] f, input logic s, input logic x,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [63:0] p, output logic [4:0] fl);
        logic signed [63:0] xa, xb;
        logic n, z, v;
        if (f == 2'd0) begin
            xa = s ? {{48{a[15]}}, a[15:0]} : {48'h0, a[15:0]};
            xb = s ? {{48{b[15]}}, b[15:0]} : {48'h0, b[15:0]};
        end else begin
            xa = s ? {{32{a[31]}}, a} : {32'h0, a};
            xb = s ? {{32{b[31]}}, b} : {32'h0, b};
        end
        p = xa * xb;
        if (f[1]) begin
            n = p[63]; z = (p == 64'h0); v = 1'b0;
        end else begin
            n = p[31]; z = (p[31:0] == 32'h0);
            v = (f == 2'd1) ? (s ? (p[63:32] != {32{p[31]}}) : (p[63:32] != 32'h0)) : 1'b0;
        end
        fl = {x, n, z, v, 1'b0};
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 200);
    endtask

    task automatic run_vec(input logic [67:0] vv, input string tag);
        logic [63:0] p;
        logic [4:0]  fl;
        int lat;
        model(vv[67:66], vv[65], vv[64], vv[63:32], vv[31:0], p, fl);
        @(negedge clk);
        form = vv[67:66]; is_signed = vv[65]; x_in = vv[64];
        opa = vv[63:32]; opb = vv[31:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R9 busy"}, {63'h0, busy}, 64'h1);
        x_in = ~x_in;
        opa = ~opa;
        wait_done(lat);
        check({tag, " R9 latency"}, 64'(lat + 1), (vv[67:66] == 2'd0) ? 64'd18 : 64'd34);
        check({tag, " R1 R2 R3 R4 product"}, {res_hi, res_lo}, p);
        check({tag, " R5 R6 R7 R8 flags"}, {59'h0, flags}, {59'h0, fl});
        @(negedge clk);
        check({tag, " R9 done pulse"}, {63'h0, done}, 64'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [63:0] p;
        logic [4:0]  fl;
        int lat;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset", {res_hi, res_lo}, 64'h0);
        check("R11 reset ctl", {57'h0, busy, done, flags}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], $sformatf("vec%0d", i));
        end

        // R10: start pulses during the run are ignored
        model(2'd2, 1'b0, 1'b1, 32'hCAFE_F00D, 32'h0000_1234, p, fl);
        @(negedge clk);
        form = 2'd2; is_signed = 1'b0; x_in = 1'b1;
        opa = 32'hCAFE_F00D; opb = 32'h0000_1234; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        form = 2'd0; is_signed = 1'b1; x_in = 1'b0;
        opa = 32'h7777_7777; opb = 32'h9999_9999; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        check("R10 mid-run start product", {res_hi, res_lo}, p);
        check("R10 mid-run start flags", {59'h0, flags}, {59'h0, fl});
        // R10: start in the done cycle is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 start at done ignored", {63'h0, busy}, 64'h0);
        @(negedge clk);
        check("R10 still idle", {62'h0, busy, done}, 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule